// File: doc/BRIEF.md
# Flag-Updating Byte ALU with Decimal Adjust

This block is the arithmetic and logic unit of a small accumulator processor. Each cycle it takes an operation code, two byte operands (the accumulator value on `opA`, the second source on `opB`) and the current eight-bit status word. It produces a byte result and the updated status word. Each class of operation writes only its own subset of the flags and leaves every other flag as it was. The unit has no decimal mode. Packed-BCD arithmetic is done by running an ordinary binary add or subtract and then applying a separate adjust operation, which reads the carry and half-carry flags.

The arithmetic and flag logic is combinational. The top level registers it, so that an operation presented with `inValid` high appears on the outputs one clock later. A new operation can be accepted every cycle. Operand fetch, addressing and instruction sequencing belong to the surrounding processor.

Top module: `byteFlagAlu`

## Requirements
- R1: Status bit layout is N=bit7, V=bit6, P=bit5, B=bit4, H=bit3, I=bit2, Z=bit1, C=bit0. No operation ever changes P, B or I. The add operation (code 0) returns opA+opB+C. It sets C to the carry out of bit 7, H to the carry out of bit 3, and V when both operands have the same sign and the result sign differs from it. N and Z follow the result.
- R2: The subtract operation (code 1) returns opA+~opB+C, so C means "no borrow". H is the carry out of bit 3 of that sum. V is set when the operand signs differ and the result sign differs from opA. N, Z and C are updated the same way as for the add.
- R3: Compare (code 2) forms opA-opB with no borrow-in. It sets C when opA>=opB (unsigned) and sets N and Z from the difference. V and H are kept, and the result output returns opA unchanged.
- R4: AND (code 3), OR (code 4) and XOR (code 5) of opA and opB update only N and Z.
- R5: Increment (code 6) and decrement (code 7) act on opA, wrap modulo 256, ignore opB and update only N and Z.
- R6: On opA, shift left (code 8) and shift right (code 9) fill with 0, while rotate left (code 10) and rotate right (code 11) fill with the old C. In all four, the bit shifted out goes to C, and N and Z follow the result.
- R7: Nibble exchange (code 12) returns {opA[3:0], opA[7:4]} and updates only N and Z.
- R8: Decimal adjust after add (code 13) first adds 0x60 and sets C if C is set or opA>0x99. It then adds 0x06 if H is set or opA[3:0]>9. N and Z follow the result, and H and V are kept.
- R9: Decimal adjust after subtract (code 14) first subtracts 0x60 and clears C if C is clear or opA>0x99. It then subtracts 0x06 if H is clear or opA[3:0]>9. N and Z follow the result, and H and V are kept.
- R10: Carry clear (code 15), carry set (code 16) and carry invert (code 17) change only C, and the result output returns opA.
- R11: Overflow clear (code 18) clears V and H together, keeps all other flags, and returns opA.
- R12: Codes 19 to 31 return opA and the status word unchanged.
- R13: Outputs are registered. An operation with inValid high shows on result and statusOut after the next rising edge, with outValid high. A cycle with inValid low leaves result and statusOut holding and drives outValid low. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 5 | Operation code |
| opA | input | 8 | Accumulator-side operand |
| opB | input | 8 | Second operand |
| statusIn | input | 8 | Current status word |
| outValid | output | 1 | Registered result valid |
| result | output | 8 | Registered result byte |
| statusOut | output | 8 | Registered next status word |

## Verification
The assertions assume that inValid is low for as long as reset is held. The bench keeps it low until reset is released and the first check has run. They also assume that opSel, opA, opB and statusIn are stable around the rising edge. The bench changes every input only on the falling edge. The decimal-adjust checks take their opA and flag values from a real binary add or subtract of two BCD numbers, so the adjust is exercised on inputs that actually occur. One wrap case also lands exactly on 0x100.

// File: rtl/byteFlagAlu_pkg.sv
package byteFlagAlu_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 5;
  localparam int NIB_W  = DATA_W / 2;

  localparam int BIT_N = 7;
  localparam int BIT_V = 6;
  localparam int BIT_H = 3;
  localparam int BIT_Z = 1;
  localparam int BIT_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_CMP  = 5'd2,
    OP_AND  = 5'd3,  OP_OR   = 5'd4,  OP_XOR  = 5'd5,
    OP_INC  = 5'd6,  OP_DEC  = 5'd7,
    OP_SHL  = 5'd8,  OP_SHR  = 5'd9,  OP_RLC  = 5'd10, OP_RRC = 5'd11,
    OP_SWAP = 5'd12, OP_DADD = 5'd13, OP_DSUB = 5'd14,
    OP_CCLR = 5'd15, OP_CSET = 5'd16, OP_CINV = 5'd17, OP_VCLR = 5'd18
  } aluOp_e;

  typedef enum logic [3:0] {
    RS_PASS, RS_ADD, RS_AND, RS_OR, RS_XOR, RS_INC, RS_DEC,
    RS_SHIFT, RS_SWAP, RS_DADD, RS_DSUB
  } resSel_e;

  typedef enum logic [2:0] {
    CS_KEEP, CS_ADD, CS_SHIFT, CS_DADD, CS_DSUB, CS_ZERO, CS_ONE, CS_INV
  } carrySel_e;

  typedef struct packed {
    resSel_e   resSel;
    carrySel_e carrySel;
    logic      invB;       // subtract path: use ~opB
    logic      useCarry;   // adder carry-in from C, else forced 1
    logic      shLeft;
    logic      shRotate;
    logic      wrNZ;
    logic      wrVH;       // V and H from the adder
    logic      clrVH;      // V and H forced to 0
  } aluStrobes_t;
endpackage

// File: rtl/byteFlagAlu_ctrl.sv
module byteFlagAlu_ctrl
  import byteFlagAlu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strb
);
  always_comb begin
    strb = '{resSel: RS_PASS, carrySel: CS_KEEP, invB: 1'b0, useCarry: 1'b1,
             shLeft: 1'b0, shRotate: 1'b0, wrNZ: 1'b0, wrVH: 1'b0, clrVH: 1'b0};
    case (opSel)
      OP_ADD:  begin strb.resSel = RS_ADD; strb.carrySel = CS_ADD;
                     strb.wrNZ = 1'b1; strb.wrVH = 1'b1; end
      OP_SUB:  begin strb.resSel = RS_ADD; strb.carrySel = CS_ADD; strb.invB = 1'b1;
                     strb.wrNZ = 1'b1; strb.wrVH = 1'b1; end
      OP_CMP:  begin strb.resSel = RS_PASS; strb.carrySel = CS_ADD; strb.invB = 1'b1;
                     strb.useCarry = 1'b0; strb.wrNZ = 1'b1; end
      OP_AND:  begin strb.resSel = RS_AND;  strb.wrNZ = 1'b1; end
      OP_OR:   begin strb.resSel = RS_OR;   strb.wrNZ = 1'b1; end
      OP_XOR:  begin strb.resSel = RS_XOR;  strb.wrNZ = 1'b1; end
      OP_INC:  begin strb.resSel = RS_INC;  strb.wrNZ = 1'b1; end
      OP_DEC:  begin strb.resSel = RS_DEC;  strb.wrNZ = 1'b1; end
      OP_SHL:  begin strb.resSel = RS_SHIFT; strb.carrySel = CS_SHIFT; strb.shLeft = 1'b1;
                     strb.wrNZ = 1'b1; end
      OP_SHR:  begin strb.resSel = RS_SHIFT; strb.carrySel = CS_SHIFT; strb.wrNZ = 1'b1; end
      OP_RLC:  begin strb.resSel = RS_SHIFT; strb.carrySel = CS_SHIFT; strb.shLeft = 1'b1;
                     strb.shRotate = 1'b1; strb.wrNZ = 1'b1; end
      OP_RRC:  begin strb.resSel = RS_SHIFT; strb.carrySel = CS_SHIFT; strb.shRotate = 1'b1;
                     strb.wrNZ = 1'b1; end
      OP_SWAP: begin strb.resSel = RS_SWAP; strb.wrNZ = 1'b1; end
      OP_DADD: begin strb.resSel = RS_DADD; strb.carrySel = CS_DADD; strb.wrNZ = 1'b1; end
      OP_DSUB: begin strb.resSel = RS_DSUB; strb.carrySel = CS_DSUB; strb.wrNZ = 1'b1; end
      OP_CCLR: strb.carrySel = CS_ZERO;
      OP_CSET: strb.carrySel = CS_ONE;
      OP_CINV: strb.carrySel = CS_INV;
      OP_VCLR: strb.clrVH = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/byteFlagAlu_dp.sv
module byteFlagAlu_dp
  import byteFlagAlu_pkg::*;
(
  input  aluStrobes_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] resNext,
  output logic [DATA_W-1:0] statusNext
);
  localparam logic [DATA_W-1:0] BCD_HI_ADJ = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] BCD_LO_ADJ = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] BCD_MAX    = DATA_W'(8'h99);
  localparam logic [NIB_W-1:0]  NIB_MAX    = NIB_W'(9);

  logic              cIn, hIn;
  logic [DATA_W-1:0] addB;
  logic              addCin;
  logic [DATA_W:0]   addSum;
  logic [NIB_W:0]    addLow;
  logic              addV;
  logic [DATA_W-1:0] shOut;
  logic              shCarry;
  logic              daHi, daLo, dsHi, dsLo;
  logic [DATA_W-1:0] daMid, daOut, dsMid, dsOut;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] nzSrc;
  logic              cNext;

  assign cIn = statusIn[BIT_C];
  assign hIn = statusIn[BIT_H];

  // shared binary adder for add, subtract and compare
  assign addB   = strb.invB ? ~opB : opB;
  assign addCin = strb.useCarry ? cIn : 1'b1;
  assign addSum = {1'b0, opA} + {1'b0, addB} + {{DATA_W{1'b0}}, addCin};
  assign addLow = {1'b0, opA[NIB_W-1:0]} + {1'b0, addB[NIB_W-1:0]} + {{NIB_W{1'b0}}, addCin};
  assign addV   = (opA[DATA_W-1] == addB[DATA_W-1]) && (addSum[DATA_W-1] != opA[DATA_W-1]);

  // shifter and rotator
  always_comb begin
    if (strb.shLeft) begin
      shOut   = {opA[DATA_W-2:0], strb.shRotate & cIn};
      shCarry = opA[DATA_W-1];
    end else begin
      shOut   = {strb.shRotate & cIn, opA[DATA_W-1:1]};
      shCarry = opA[0];
    end
  end

  // decimal adjust after add / subtract
  assign daHi  = cIn || (opA > BCD_MAX);
  assign daLo  = hIn || (opA[NIB_W-1:0] > NIB_MAX);
  assign daMid = daHi ? opA + BCD_HI_ADJ : opA;
  assign daOut = daLo ? daMid + BCD_LO_ADJ : daMid;
  assign dsHi  = !cIn || (opA > BCD_MAX);
  assign dsLo  = !hIn || (opA[NIB_W-1:0] > NIB_MAX);
  assign dsMid = dsHi ? opA - BCD_HI_ADJ : opA;
  assign dsOut = dsLo ? dsMid - BCD_LO_ADJ : dsMid;

  always_comb begin
    case (strb.resSel)
      RS_ADD:   aluOut = addSum[DATA_W-1:0];
      RS_AND:   aluOut = opA & opB;
      RS_OR:    aluOut = opA | opB;
      RS_XOR:   aluOut = opA ^ opB;
      RS_INC:   aluOut = opA + 1'b1;
      RS_DEC:   aluOut = opA - 1'b1;
      RS_SHIFT: aluOut = shOut;
      RS_SWAP:  aluOut = {opA[NIB_W-1:0], opA[DATA_W-1:NIB_W]};
      RS_DADD:  aluOut = daOut;
      RS_DSUB:  aluOut = dsOut;
      default:  aluOut = opA;
    endcase
  end

  always_comb begin
    case (strb.carrySel)
      CS_ADD:   cNext = addSum[DATA_W];
      CS_SHIFT: cNext = shCarry;
      CS_DADD:  cNext = daHi;
      CS_DSUB:  cNext = !dsHi;
      CS_ZERO:  cNext = 1'b0;
      CS_ONE:   cNext = 1'b1;
      CS_INV:   cNext = !cIn;
      default:  cNext = cIn;
    endcase
  end

  // compare sets N/Z from the difference but returns opA
  assign nzSrc   = (strb.resSel == RS_PASS) ? addSum[DATA_W-1:0] : aluOut;
  assign resNext = aluOut;

  always_comb begin
    statusNext        = statusIn;
    statusNext[BIT_C] = cNext;
    if (strb.wrNZ) begin
      statusNext[BIT_N] = nzSrc[DATA_W-1];
      statusNext[BIT_Z] = (nzSrc == '0);
    end
    if (strb.wrVH) begin
      statusNext[BIT_V] = addV;
      statusNext[BIT_H] = addLow[NIB_W];
    end else if (strb.clrVH) begin
      statusNext[BIT_V] = 1'b0;
      statusNext[BIT_H] = 1'b0;
    end
  end
endmodule

// File: rtl/byteFlagAlu.sv
module byteFlagAlu
  import byteFlagAlu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] statusIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] statusOut
);
  aluStrobes_t       strb;
  logic [DATA_W-1:0] resNext, statusNext;

  byteFlagAlu_ctrl u_ctrl (.opSel(opSel), .strb(strb));

  byteFlagAlu_dp u_dp (
    .strb(strb), .opA(opA), .opB(opB), .statusIn(statusIn),
    .resNext(resNext), .statusNext(statusNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      statusOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result    <= resNext;
        statusOut <= statusNext;
      end
    end
  end

  AST_PBI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> statusOut[5:4] == $past(statusIn[5:4]) && statusOut[2] == $past(statusIn[2])); // R1

  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opSel == OP_CMP |=> result == $past(opA)
      && statusOut[6:2] == $past(statusIn[6:2])); // R3

  AST_LOGIC_NZ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR)
      |=> statusOut[6:2] == $past(statusIn[6:2]) && statusOut[0] == $past(statusIn[0])
        && statusOut[1] == (result == '0) && statusOut[7] == result[7]); // R4

  AST_VH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opSel == OP_VCLR |=> !statusOut[6] && !statusOut[3]
      && result == $past(opA)); // R11

  AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opSel > OP_VCLR |=> result == $past(opA) && statusOut == $past(statusIn)); // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(result) && $stable(statusOut)); // R13
endmodule

// File: tb/byteFlagAlu_tb.sv
module byteFlagAlu_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] opA = '0, opB = '0, statusIn = '0;
  logic       outValid;
  logic [7:0] result, statusOut;
  int         nChecks = 0;
  int         nFails = 0;

  always #4 clk = ~clk;

  byteFlagAlu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .opA(opA), .opB(opB),
    .statusIn(statusIn), .outValid(outValid), .result(result), .statusOut(statusOut)
  );

  task automatic check(input string tag, input logic v, input logic [7:0] r, input logic [7:0] s);
    nChecks++;
    if (outValid !== v || result !== r || statusOut !== s) begin
      nFails++;
      $display("FAIL %s: valid/result/status = %0b/%02h/%02h, expected %0b/%02h/%02h",
               tag, outValid, result, statusOut, v, r, s);
    end
  endtask

  task automatic applyOp(input string tag, input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] st,
                         input logic [7:0] expR, input logic [7:0] expS);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; statusIn = st;
    @(posedge clk); #1;
    check(tag, 1'b1, expR, expS);
  endtask

  task automatic testReset();
    check("R13 reset", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic testAddSub();
    applyOp("R1 add overflow+half", 5'd0, 8'h3A, 8'h47, 8'h00, 8'h81, 8'hC8);
    applyOp("R1 add wrap to zero",  5'd0, 8'hFF, 8'h00, 8'h25, 8'h00, 8'h2F);
    applyOp("R2 sub no borrow",     5'd1, 8'h50, 8'h30, 8'h01, 8'h20, 8'h09);
    applyOp("R2 sub overflow",      5'd1, 8'h50, 8'hB0, 8'h01, 8'hA0, 8'hC8);
    applyOp("R2 sub C clear",       5'd1, 8'h10, 8'h01, 8'h00, 8'h0E, 8'h01);
  endtask

  task automatic testCompare();
    applyOp("R3 cmp equal",   5'd2, 8'h40, 8'h40, 8'hC8, 8'h40, 8'h4B);
    applyOp("R3 cmp less",    5'd2, 8'h10, 8'h20, 8'h03, 8'h10, 8'h80);
  endtask

  task automatic testLogic();
    applyOp("R4 and zero", 5'd3, 8'hF0, 8'h0F, 8'hC9, 8'h00, 8'h4B);
    applyOp("R4 or",       5'd4, 8'h80, 8'h01, 8'h02, 8'h81, 8'h80);
    applyOp("R4 xor",      5'd5, 8'hFF, 8'h0F, 8'h41, 8'hF0, 8'hC1);
  endtask

  task automatic testIncDec();
    applyOp("R5 inc wrap", 5'd6, 8'hFF, 8'h55, 8'h80, 8'h00, 8'h02);
    applyOp("R5 dec wrap", 5'd7, 8'h00, 8'hAA, 8'h03, 8'hFF, 8'h81);
  endtask

  task automatic testShift();
    applyOp("R6 shl",      5'd8,  8'h81, 8'h00, 8'h00, 8'h02, 8'h01);
    applyOp("R6 shr zero", 5'd9,  8'h01, 8'h00, 8'h80, 8'h00, 8'h03);
    applyOp("R6 rlc",      5'd10, 8'h40, 8'h00, 8'h01, 8'h81, 8'h80);
    applyOp("R6 rrc",      5'd11, 8'h01, 8'h00, 8'h01, 8'h80, 8'h81);
    applyOp("R7 swap",     5'd12, 8'h3C, 8'h00, 8'h01, 8'hC3, 8'h81);
  endtask

  task automatic testDecimal();
    applyOp("R8 adjust half",      5'd13, 8'h41, 8'h00, 8'h08, 8'h47, 8'h08);
    applyOp("R8 adjust both wrap", 5'd13, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h03);
    applyOp("R9 adjust low",       5'd14, 8'h2D, 8'h00, 8'h01, 8'h27, 8'h01);
    applyOp("R9 adjust borrow",    5'd14, 8'hF0, 8'h00, 8'h08, 8'h90, 8'h88);
  endtask

  task automatic testFlagOps();
    applyOp("R10 carry clear",  5'd15, 8'h5A, 8'h00, 8'hFF, 8'h5A, 8'hFE);
    applyOp("R10 carry set",    5'd16, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h01);
    applyOp("R10 carry invert", 5'd17, 8'h5A, 8'h00, 8'h01, 8'h5A, 8'h00);
    applyOp("R10 invert back",  5'd17, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h01);
    applyOp("R11 clear V and H", 5'd18, 8'h77, 8'h00, 8'hFF, 8'h77, 8'hB7);
    applyOp("R12 unused code",  5'd25, 8'h33, 8'hCC, 8'hA5, 8'h33, 8'hA5);
  endtask

  task automatic testHold();
    applyOp("R13 load", 5'd4, 8'h12, 8'h21, 8'h00, 8'h33, 8'h00);
    @(negedge clk);
    inValid = 1'b0; opSel = 5'd0; opA = 8'hFF; opB = 8'hFF; statusIn = 8'hFF;
    @(posedge clk); #1;
    check("R13 idle holds", 1'b0, 8'h33, 8'h00);
  endtask

  initial begin
    #(8 * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testAddSub();
    testCompare();
    testLogic();
    testIncDec();
    testShift();
    testDecimal();
    testFlagOps();
    testHold();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule